// File: doc/BRIEF.md
# Dual-Path Latching Bus Transceiver

This block carries data in both directions between two 18-bit ports, A and B. Each direction has a storage register of its own, with three control inputs: a latch enable, a capture strobe and an output enable. With its latch enable high, a path is transparent: its destination follows its source. With the latch enable low, the stored word is held until a rising strobe edge captures a new one. The output enable decides whether the destination port is driven at all.

The block is meant for a synchronous fabric. Each bidirectional port is split into a data input, a data output and a drive-enable output; the pad logic builds the tri-state driver from these. A drive-enable of 0 means the port is high-impedance. The strobes are not used as clocks. They are sampled in the core clock domain, and their rising edges are found by comparing each sample with the one before it.

The A-to-B enable is active high and the B-to-A enable is active low. Every control input is sampled on the core clock, and every output comes from a register.

Top module: `dual_path_xcvr`

## Requirements
- R1: While `rst` is high at a clock edge, both stored words become zero and both drive-enables become 0. Zero on a drive-enable means high-impedance.
- R2: At a clock edge where `ab_le` is 1, `b_out` takes the value on `a_in` and shows it from that edge on (one cycle of latency in transparent mode).
- R3: At a clock edge where `ab_le` is 0 and no rising strobe edge is seen, `b_out` keeps its value. Changes on `a_in` have no effect.
- R4: At a clock edge where `ab_le` is 0, `ab_stb` is 1 and the previous sample of `ab_stb` was 0, `b_out` takes the value on `a_in`.
- R5: `b_oe` takes the value of `ab_en` at each clock edge (active high). While `b_oe` is 0 the B port is undriven, whatever the other inputs are.
- R6: `a_oe` takes the inverse of `ba_en_n` at each clock edge (active low). While `ba_en_n` is 1 the A port is undriven.
- R7: The B-to-A path follows the rules of R2, R3, R4 and R8 with `ba_le`, `ba_stb`, `b_in` and `a_out`. It works independently of the A-to-B path.
- R8: Suppose `ab_le` falls while `ab_stb` is already 1, so no rising edge is seen. Then `b_out` keeps the word loaded in the last transparent cycle. If instead `ab_le` falls in the same cycle as a rising strobe edge, the new `a_in` is captured.
- R9: All 18 bits of a path are stored and driven together under that path's single set of controls. Alternating bit patterns pass unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous reset, active high |
| a_in | input | 18 | Data arriving on port A |
| a_out | output | 18 | Data driven onto port A (B-to-A storage) |
| a_oe | output | 1 | Drive enable for port A; 0 means high-impedance |
| b_in | input | 18 | Data arriving on port B |
| b_out | output | 18 | Data driven onto port B (A-to-B storage) |
| b_oe | output | 1 | Drive enable for port B; 0 means high-impedance |
| ab_le | input | 1 | A-to-B latch enable; 1 selects transparent mode |
| ab_stb | input | 1 | A-to-B capture strobe; its rising edge captures |
| ab_en | input | 1 | A-to-B output enable, active high |
| ba_le | input | 1 | B-to-A latch enable; 1 selects transparent mode |
| ba_stb | input | 1 | B-to-A capture strobe; its rising edge captures |
| ba_en_n | input | 1 | B-to-A output enable, active low |

## Verification
Every result is due exactly one core clock edge after the inputs that cause it are sampled. This covers transparent data, captured data, held data and both drive-enables. A rising strobe edge counts only against the strobe sample taken one edge earlier. The bench changes inputs on the falling clock edge. It steps its reference model on the rising edge, using the values just sampled, and compares all four outputs at the next falling edge. Each compare is therefore made one cycle after its cause. The directed cases cover a latch enable that falls while the strobe is high, and one that falls together with a strobe rise, in both directions.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  typedef enum logic [1:0] {
    MODE_HOLD    = 2'd0,
    MODE_PASS    = 2'd1,
    MODE_CAPTURE = 2'd2
  } store_mode_e;
endpackage

// File: rtl/xcvr_strobe_edge.sv
module xcvr_strobe_edge (
  input  logic clk,
  input  logic stb,
  output logic rise
);
  logic stb_q;

  // Previous sample; tracks the strobe even during reset so no false edge follows it.
  always_ff @(posedge clk) begin
    stb_q <= stb;
  end

  assign rise = stb & ~stb_q;
endmodule

// File: rtl/xcvr_path.sv
module xcvr_path
  import xcvr_pkg::*;
#(
  parameter int W      = 18,
  parameter bit OE_LOW = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  input  logic         le,
  input  logic         stb,
  input  logic         en,
  output logic [W-1:0] dout,
  output logic         oe
);
  logic        rise;
  logic        en_act;
  store_mode_e mode;
  logic [W-1:0] store_q;
  logic         oe_q;

  xcvr_strobe_edge i_edge (
    .clk  (clk),
    .stb  (stb),
    .rise (rise)
  );

  generate
    if (OE_LOW) begin : g_oe_low
      assign en_act = ~en;
    end else begin : g_oe_high
      assign en_act = en;
    end
  endgenerate

  always_comb begin
    if (le)        mode = MODE_PASS;
    else if (rise) mode = MODE_CAPTURE;
    else           mode = MODE_HOLD;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      store_q <= '0;
      oe_q    <= 1'b0;
    end else begin
      oe_q <= en_act;
      case (mode)
        MODE_PASS, MODE_CAPTURE: store_q <= din;
        default:                 store_q <= store_q;
      endcase
    end
  end

  assign dout = store_q;
  assign oe   = oe_q;
endmodule

// File: rtl/dual_path_xcvr.sv
module dual_path_xcvr #(
  parameter int DATA_W = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] a_in,
  output logic [DATA_W-1:0] a_out,
  output logic              a_oe,
  input  logic [DATA_W-1:0] b_in,
  output logic [DATA_W-1:0] b_out,
  output logic              b_oe,
  input  logic              ab_le,
  input  logic              ab_stb,
  input  logic              ab_en,
  input  logic              ba_le,
  input  logic              ba_stb,
  input  logic              ba_en_n
);
  xcvr_path #(.W(DATA_W), .OE_LOW(1'b0)) i_ab (
    .clk  (clk),
    .rst  (rst),
    .din  (a_in),
    .le   (ab_le),
    .stb  (ab_stb),
    .en   (ab_en),
    .dout (b_out),
    .oe   (b_oe)
  );

  xcvr_path #(.W(DATA_W), .OE_LOW(1'b1)) i_ba (
    .clk  (clk),
    .rst  (rst),
    .din  (b_in),
    .le   (ba_le),
    .stb  (ba_stb),
    .en   (ba_en_n),
    .dout (a_out),
    .oe   (a_oe)
  );
endmodule

// File: rtl/xcvr_checker.sv
module xcvr_checker #(
  parameter int W = 18
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] a_in,
  input logic [W-1:0] a_out,
  input logic         a_oe,
  input logic [W-1:0] b_in,
  input logic [W-1:0] b_out,
  input logic         b_oe,
  input logic         ab_le,
  input logic         ab_stb,
  input logic         ab_en,
  input logic         ba_le,
  input logic         ba_stb,
  input logic         ba_en_n
);
  AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> (a_out == '0 && b_out == '0 && !a_oe && !b_oe)); // R1
  AST_AB_PASS: assert property (@(posedge clk) disable iff (rst) ab_le |=> b_out == $past(a_in)); // R2
  AST_AB_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!ab_le && (!ab_stb || $past(ab_stb))) |=> $stable(b_out)); // R3
  AST_AB_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    (!ab_le && ab_stb && !$past(ab_stb)) |=> b_out == $past(a_in)); // R4
  AST_AB_ENABLE: assert property (@(posedge clk) disable iff (rst) 1'b1 |=> b_oe == $past(ab_en)); // R5
  AST_BA_ENABLE: assert property (@(posedge clk) disable iff (rst) 1'b1 |=> a_oe == !$past(ba_en_n)); // R6
  AST_BA_PASS: assert property (@(posedge clk) disable iff (rst) ba_le |=> a_out == $past(b_in)); // R7
  AST_BA_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!ba_le && (!ba_stb || $past(ba_stb))) |=> $stable(a_out)); // R7
  AST_LE_FALL_STB_HIGH: assert property (@(posedge clk) disable iff (rst)
    ($past(ab_le) && !ab_le && ab_stb && $past(ab_stb)) |=> $stable(b_out)); // R8
endmodule

bind dual_path_xcvr xcvr_checker #(.W(DATA_W)) i_xcvr_checker (
  .clk     (clk),
  .rst     (rst),
  .a_in    (a_in),
  .a_out   (a_out),
  .a_oe    (a_oe),
  .b_in    (b_in),
  .b_out   (b_out),
  .b_oe    (b_oe),
  .ab_le   (ab_le),
  .ab_stb  (ab_stb),
  .ab_en   (ab_en),
  .ba_le   (ba_le),
  .ba_stb  (ba_stb),
  .ba_en_n (ba_en_n)
);

// File: tb/test_dual_path_xcvr.sv
`timescale 1ns/1ps
module test_dual_path_xcvr;
  localparam int W = 18;

  logic         clk = 1'b0;
  logic         rst;
  logic [W-1:0] a_in, b_in;
  logic [W-1:0] a_out, b_out;
  logic         a_oe, b_oe;
  logic         ab_le, ab_stb, ab_en;
  logic         ba_le, ba_stb, ba_en_n;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // reference model state
  logic [W-1:0] m_b, m_a;
  logic         m_boe, m_aoe;
  logic         m_ab_sq, m_ba_sq;
  logic         m_ab_lep, m_ba_lep;
  string        tag_ab, tag_ba;

  always #2.5 clk = ~clk;

  dual_path_xcvr #(.DATA_W(W)) i_dual_path_xcvr (
    .clk(clk), .rst(rst),
    .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_out(b_out), .b_oe(b_oe),
    .ab_le(ab_le), .ab_stb(ab_stb), .ab_en(ab_en),
    .ba_le(ba_le), .ba_stb(ba_stb), .ba_en_n(ba_en_n)
  );

  function automatic string mode_tag(logic r, logic le, logic stb, logic sq, logic lep);
    if (r)                         return "R1";
    if (le)                        return "R2";
    if (stb && !sq)                return "R4";
    if (lep && stb && sq)          return "R8";
    return "R3";
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    tag_ab = mode_tag(rst, ab_le, ab_stb, m_ab_sq, m_ab_lep);
    tag_ba = mode_tag(rst, ba_le, ba_stb, m_ba_sq, m_ba_lep);
    if (rst) begin
      m_b = '0; m_a = '0; m_boe = 1'b0; m_aoe = 1'b0;
    end else begin
      if (ab_le || (ab_stb && !m_ab_sq)) m_b = a_in;
      if (ba_le || (ba_stb && !m_ba_sq)) m_a = b_in;
      m_boe = ab_en;
      m_aoe = !ba_en_n;
    end
    m_ab_sq = ab_stb; m_ba_sq = ba_stb;
    m_ab_lep = ab_le; m_ba_lep = ba_le;
    @(negedge clk);
    chk({tag_ab, " b_out"}, 32'(b_out), 32'(m_b));
    chk(rst ? "R1 b_oe" : "R5 b_oe", 32'(b_oe), 32'(m_boe));
    chk({tag_ba, " R7 a_out"}, 32'(a_out), 32'(m_a));
    chk(rst ? "R1 a_oe" : "R6 a_oe", 32'(a_oe), 32'(m_aoe));
  endtask

  task automatic drive(logic le1, logic s1, logic e1, logic [W-1:0] d1,
                       logic le2, logic s2, logic e2n, logic [W-1:0] d2);
    ab_le = le1; ab_stb = s1; ab_en = e1; a_in = d1;
    ba_le = le2; ba_stb = s2; ba_en_n = e2n; b_in = d2;
    step();
  endtask

  initial begin
    void'($urandom(32'd20240611));
    m_b = '0; m_a = '0; m_boe = 1'b0; m_aoe = 1'b0;
    m_ab_sq = 1'b0; m_ba_sq = 1'b0; m_ab_lep = 1'b0; m_ba_lep = 1'b0;
    rst = 1'b1;
    ab_le = 1'b0; ab_stb = 1'b0; ab_en = 1'b1; a_in = 18'h3FFFF;
    ba_le = 1'b0; ba_stb = 1'b0; ba_en_n = 1'b0; b_in = 18'h3FFFF;
    repeat (4) step();
    // R1: reset leaves zero words and undriven ports
    chk("R1 b_out reset", 32'(b_out), 32'h0);
    chk("R1 b_oe reset", 32'(b_oe), 32'h0);
    chk("R1 a_out reset", 32'(a_out), 32'h0);
    chk("R1 a_oe reset", 32'(a_oe), 32'h0);
    rst = 1'b0;

    // R9: alternating patterns through transparent mode, both directions
    drive(1, 0, 1, 18'h2AAAA, 1, 0, 0, 18'h15555);
    chk("R9 b_out", 32'(b_out), 32'h2AAAA);
    chk("R9 a_out", 32'(a_out), 32'h15555);
    drive(1, 0, 1, 18'h15555, 1, 0, 0, 18'h2AAAA);
    chk("R9 b_out", 32'(b_out), 32'h15555);
    chk("R9 a_out", 32'(a_out), 32'h2AAAA);

    // R3: hold with changing inputs
    drive(0, 0, 1, 18'h00F0F, 0, 0, 0, 18'h3F0F0);
    drive(0, 0, 1, 18'h12345, 0, 0, 0, 18'h0ABCD);
    chk("R3 b_out held", 32'(b_out), 32'h15555);
    chk("R3 R7 a_out held", 32'(a_out), 32'h2AAAA);

    // R4: capture on strobe rise, then high strobe does not recapture
    drive(0, 1, 1, 18'h1C3A5, 0, 1, 0, 18'h0F00F);
    chk("R4 b_out capture", 32'(b_out), 32'h1C3A5);
    chk("R4 R7 a_out capture", 32'(a_out), 32'h0F00F);
    drive(0, 1, 1, 18'h00001, 0, 1, 0, 18'h00002);
    chk("R3 b_out strobe high", 32'(b_out), 32'h1C3A5);

    // R8: latch enable falls while strobe already high
    drive(1, 1, 1, 18'h2468A, 1, 1, 0, 18'h13579);
    drive(0, 1, 1, 18'h3FFFF, 0, 1, 0, 18'h3FFFF);
    chk("R8 b_out keep", 32'(b_out), 32'h2468A);
    chk("R8 R7 a_out keep", 32'(a_out), 32'h13579);

    // R8: latch enable falls together with strobe rise
    drive(1, 0, 1, 18'h11111, 1, 0, 0, 18'h22222);
    drive(0, 1, 1, 18'h33333, 0, 1, 0, 18'h04444);
    chk("R8 b_out simultaneous", 32'(b_out), 32'h33333);
    chk("R8 R7 a_out simultaneous", 32'(a_out), 32'h04444);

    // R5 / R6: disabled ports
    drive(1, 0, 0, 18'h0AAAA, 1, 0, 1, 18'h05555);
    chk("R5 b_oe off", 32'(b_oe), 32'h0);
    chk("R6 a_oe off", 32'(a_oe), 32'h0);

    // constrained random mix
    for (int i = 0; i < 600; i++) begin
      drive(($urandom % 6) == 0, $urandom % 2, ($urandom % 4) != 0, W'($urandom),
            ($urandom % 6) == 0, $urandom % 2, ($urandom % 4) == 0, W'($urandom));
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule